// File: doc/BRIEF.md
# Time-of-Day Clock with Alarm Match

This block is a real-time clock. It counts tenths of a second, seconds, minutes and hours in BCD across two 16-bit counters. A synchronous line-frequency pulse (one pulse per mains cycle) goes through a prescaler. Two control bits set its ratio so that each input rate of 50, 60 or 100 Hz yields one advance per tenth of a second. The fast counter holds seconds and tenths. The slow counter holds hours and minutes and steps when the fast counter rolls over.

Each counter has a 16-bit alarm register and an equality comparator. A comparator that is enabled drives its counter's output pin with the match result in place of the default terminal-count pulse. When time-of-day chaining is requested and both comparators are enabled, the second output fires only on a full 32-bit match of hours, minutes, seconds and tenths. The first output keeps its own 16-bit match. A small write port loads either counter or either alarm.

Top module: `tod_rtc`

## Requirements
- R1: The prescaler ratio is set by `ctrl_i[1:0]`: 2'b01 divides line pulses by 5, 2'b10 by 6, 2'b11 by 10, and 2'b00 advances on every pulse. The first advance after a counter load comes on the N-th pulse.
- R2: `cnt1_o` holds seconds as two BCD digits in bits [15:8] and tenths as one BCD digit in bits [3:0], with bits [7:4] always zero. Tenths wrap 9 to 0 and carry into seconds. Seconds wrap 59 to 00.
- R3: `cnt2_o` holds hours as two BCD digits in [15:8] and minutes in [7:0]. It advances only in the cycle where `cnt1_o` wraps from 59.9 to 00.0. Minutes wrap 59 to 00, and hours wrap 23 to 00.
- R4: With `wr_en_i` high, `wr_sel_i` picks the target: 0 is counter 1 (bits [7:4] forced to zero), 1 is counter 2, 2 is alarm 1 and 3 is alarm 2. A counter write appears on the next clock, clears the prescaler phase and blocks any advance in that cycle.
- R5: With `ctrl_i[2]` high, `out1_o` is high exactly while `cnt1_o` equals alarm 1, and it stays high until the count moves off the match.
- R6: With `ctrl_i[3]` high and chaining off, `out2_o` is high exactly while `cnt2_o` equals alarm 2.
- R7: With `tod_mode_i`, `ctrl_i[2]` and `ctrl_i[3]` all high, `out2_o` requires both `cnt1_o` to equal alarm 1 and `cnt2_o` to equal alarm 2, while `out1_o` still follows only the 16-bit match of counter 1.
- R8: With its comparator disabled, `out1_o` is a one-cycle pulse in the cycle after counter 1 wraps to 00.0. Likewise, `out2_o` is a one-cycle pulse in the cycle after counter 2 wraps from 23:59 to 00:00.
- R9: Without a line pulse and without a counter write, both counters hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_pulse_i | input | 1 | One-cycle pulse per line-frequency period |
| tod_mode_i | input | 1 | Time-of-day chaining of comparator 2 onto comparator 1 |
| ctrl_i | input | 4 | [1:0] prescaler ratio, [2] comparator 1 enable, [3] comparator 2 enable |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write target select |
| wr_data_i | input | 16 | Write data |
| cnt1_o | output | 16 | Seconds and tenths counter |
| cnt2_o | output | 16 | Hours and minutes counter |
| out1_o | output | 1 | Counter 1 output pin |
| out2_o | output | 1 | Counter 2 output pin |

## Verification
A line pulse or a write that is presented before a rising edge shows up in `cnt1_o` and `cnt2_o` right after that edge. This is because the prescaler decision is combinational into the counter registers. The match outputs are combinational from registered counters and alarms, so they are due in the same cycle. The terminal-count pulses come from one more register, but they are also visible directly after the edge on which the wrap happens, and they drop one edge later. The bench drives every input on the falling edge, lets one rising edge pass, and compares all four outputs against its model on the next falling edge.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam int unsigned TOD_W   = 16;
  localparam int unsigned PH_W    = 4;
  localparam int unsigned N_CNT   = 2;

  typedef enum logic [1:0] {
    SEL_CNT1 = 2'd0,
    SEL_CNT2 = 2'd1,
    SEL_ALM1 = 2'd2,
    SEL_ALM2 = 2'd3
  } wr_sel_e;

  // {carry, next} for a two-digit BCD field that wraps after last
  function automatic logic [8:0] bcd2_inc(logic [7:0] v, logic [7:0] last);
    if (v >= last)          return 9'h100;
    if (v[3:0] >= 4'd9)     return {1'b0, v[7:4] + 4'd1, 4'h0};
    return {1'b0, v[7:4], v[3:0] + 4'd1};
  endfunction
endpackage

// File: rtl/tod_prescaler.sv
module tod_prescaler
  import tod_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pulse_i,
  input  logic       clr_i,
  input  logic [1:0] ratio_i,
  output logic       tick_o
);
  logic [PH_W-1:0] ph_q;
  logic [PH_W-1:0] last_ph;
  logic            at_last;

  always_comb begin
    unique case (ratio_i)
      2'b01:   last_ph = PH_W'(4);
      2'b10:   last_ph = PH_W'(5);
      2'b11:   last_ph = PH_W'(9);
      default: last_ph = '0;
    endcase
  end

  assign at_last = (ph_q >= last_ph);
  assign tick_o  = pulse_i & ~clr_i & at_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ph_q <= '0;
    else if (clr_i)   ph_q <= '0;
    else if (pulse_i) ph_q <= at_last ? '0 : ph_q + 1'b1;
  end
endmodule

// File: rtl/tod_bcd_counter.sv
module tod_bcd_counter
  import tod_pkg::*;
#(
  parameter bit         HAS_TENTHS = 1'b1,
  parameter logic [7:0] LO_LAST    = 8'h59,
  parameter logic [7:0] HI_LAST    = 8'h59
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [TOD_W-1:0] load_val_i,
  input  logic             inc_i,
  output logic [TOD_W-1:0] cnt_o,
  output logic             wrap_o
);
  localparam logic [TOD_W-1:0] LOAD_MASK = HAS_TENTHS ? 16'hFF0F : 16'hFFFF;

  logic [TOD_W-1:0] cnt_q;
  logic [7:0]       lo_next;
  logic             lo_carry;
  logic [8:0]       hi_res;

  generate
    if (HAS_TENTHS) begin : g_tenths
      assign lo_carry = (cnt_q[3:0] >= 4'd9);
      assign lo_next  = {4'h0, lo_carry ? 4'h0 : cnt_q[3:0] + 4'd1};
    end else begin : g_minutes
      logic [8:0] lo_res;
      assign lo_res   = bcd2_inc(cnt_q[7:0], LO_LAST);
      assign lo_carry = lo_res[8];
      assign lo_next  = lo_res[7:0];
    end
  endgenerate

  assign hi_res = bcd2_inc(cnt_q[15:8], HI_LAST);
  assign wrap_o = inc_i & ~load_i & lo_carry & hi_res[8];
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i & LOAD_MASK;
    else if (inc_i)  cnt_q <= {lo_carry ? hi_res[7:0] : cnt_q[15:8], lo_next};
  end
endmodule

// File: rtl/tod_alarm_cmp.sv
module tod_alarm_cmp
  import tod_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [TOD_W-1:0] wr_data_i,
  input  logic [TOD_W-1:0] cnt_i,
  output logic [TOD_W-1:0] alarm_o,
  output logic             match_o
);
  logic [TOD_W-1:0] alarm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   alarm_q <= '0;
    else if (wr_i) alarm_q <= wr_data_i;
  end

  assign alarm_o = alarm_q;
  assign match_o = (cnt_i == alarm_q);
endmodule

// File: rtl/tod_rtc.sv
module tod_rtc
  import tod_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             line_pulse_i,
  input  logic             tod_mode_i,
  input  logic [3:0]       ctrl_i,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_sel_i,
  input  logic [TOD_W-1:0] wr_data_i,
  output logic [TOD_W-1:0] cnt1_o,
  output logic [TOD_W-1:0] cnt2_o,
  output logic             out1_o,
  output logic             out2_o
);
  logic                         cnt_wr;
  logic                         tick;
  logic [N_CNT-1:0]             wrap;
  logic [N_CNT-1:0]             tc_q;
  logic [N_CNT-1:0]             match;
  logic [N_CNT-1:0][TOD_W-1:0]  cnt;
  logic [N_CNT-1:0][TOD_W-1:0]  alarm;
  logic                         chain;

  assign cnt_wr = wr_en_i & ~wr_sel_i[1];

  tod_prescaler u_pre (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pulse_i (line_pulse_i),
    .clr_i   (cnt_wr),
    .ratio_i (ctrl_i[1:0]),
    .tick_o  (tick)
  );

  tod_bcd_counter #(.HAS_TENTHS(1'b1), .LO_LAST(8'h09), .HI_LAST(8'h59)) u_cnt_sec (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (wr_en_i && wr_sel_i == SEL_CNT1),
    .load_val_i (wr_data_i),
    .inc_i      (tick),
    .cnt_o      (cnt[0]),
    .wrap_o     (wrap[0])
  );

  tod_bcd_counter #(.HAS_TENTHS(1'b0), .LO_LAST(8'h59), .HI_LAST(8'h23)) u_cnt_hm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (wr_en_i && wr_sel_i == SEL_CNT2),
    .load_val_i (wr_data_i),
    .inc_i      (wrap[0]),
    .cnt_o      (cnt[1]),
    .wrap_o     (wrap[1])
  );

  generate
    for (genvar k = 0; k < N_CNT; k++) begin : g_alm
      tod_alarm_cmp u_cmp (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_i      (wr_en_i && wr_sel_i == 2'(k + 2)),
        .wr_data_i (wr_data_i),
        .cnt_i     (cnt[k]),
        .alarm_o   (alarm[k]),
        .match_o   (match[k])
      );
    end
  endgenerate

  // counter 2 only wraps inside a counter 1 wrap
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tc_q <= '0;
    else         tc_q <= {wrap[1], wrap[0]};
  end

  assign chain  = tod_mode_i & ctrl_i[2] & ctrl_i[3];
  assign cnt1_o = cnt[0];
  assign cnt2_o = cnt[1];
  assign out1_o = ctrl_i[2] ? match[0] : tc_q[0];
  assign out2_o = ctrl_i[3] ? (match[1] & (~chain | match[0])) : tc_q[1];
endmodule

// File: rtl/tod_rtc_chk.sv
module tod_rtc_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        line_pulse_i,
  input logic        tod_mode_i,
  input logic [3:0]  ctrl_i,
  input logic        wr_en_i,
  input logic [1:0]  wr_sel_i,
  input logic [15:0] wr_data_i,
  input logic [15:0] cnt1_o,
  input logic [15:0] cnt2_o,
  input logic        out1_o,
  input logic        out2_o,
  input logic [15:0] alarm1
);
  // R9
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!line_pulse_i && !(wr_en_i && !wr_sel_i[1])) |=> ($stable(cnt1_o) && $stable(cnt2_o)));

  // R4
  cnt1_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i == 2'd0) |=> (cnt1_o == ($past(wr_data_i) & 16'hFF0F)));

  // R3
  cnt2_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(cnt2_o) && !$past(wr_en_i && wr_sel_i == 2'd1)) |-> (cnt1_o == 16'h0000));

  // R7
  chain_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tod_mode_i && ctrl_i[2] && ctrl_i[3] && out2_o) |-> out1_o);

  // R5
  cmp1_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_i[2] |-> (out1_o == (cnt1_o == alarm1)));

  // R8
  tc1_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_i[2] && out1_o) |=> !(!ctrl_i[2] && out1_o));
endmodule

bind tod_rtc tod_rtc_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .line_pulse_i (line_pulse_i),
  .tod_mode_i   (tod_mode_i),
  .ctrl_i       (ctrl_i),
  .wr_en_i      (wr_en_i),
  .wr_sel_i     (wr_sel_i),
  .wr_data_i    (wr_data_i),
  .cnt1_o       (cnt1_o),
  .cnt2_o       (cnt2_o),
  .out1_o       (out1_o),
  .out2_o       (out2_o),
  .alarm1       (alarm[0])
);

// File: tb/tod_rtc_tb.sv
`timescale 1ns/1ps
module tod_rtc_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        line_pulse_i = 1'b0;
  logic        tod_mode_i = 1'b0;
  logic [3:0]  ctrl_i = 4'h0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  wr_sel_i = 2'd0;
  logic [15:0] wr_data_i = 16'h0;
  logic [15:0] cnt1_o, cnt2_o;
  logic        out1_o, out2_o;

  int checks = 0;
  int errors = 0;

  logic [15:0] m_c1 = 0, m_c2 = 0, m_a1 = 0, m_a2 = 0;
  int          m_ph = 0;
  bit          m_tc1 = 0, m_tc2 = 0;

  always #5 clk_i = ~clk_i;

  tod_rtc u_dut (.*);

  initial begin
    #2_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog: run did not end, actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  function automatic int c1_int(logic [15:0] c);
    return (c[15:12] * 10 + c[11:8]) * 10 + c[3:0];
  endfunction
  function automatic logic [15:0] int_c1(int n);
    int s = n / 10;
    return {4'(s / 10), 4'(s % 10), 4'h0, 4'(n % 10)};
  endfunction
  function automatic int c2_int(logic [15:0] c);
    return (c[15:12] * 10 + c[11:8]) * 60 + c[7:4] * 10 + c[3:0];
  endfunction
  function automatic logic [15:0] int_c2(int n);
    int h = n / 60;
    int m = n % 60;
    return {4'(h / 10), 4'(h % 10), 4'(m / 10), 4'(m % 10)};
  endfunction
  function automatic int ratio(logic [1:0] r);
    case (r)
      2'b01:   return 5;
      2'b10:   return 6;
      2'b11:   return 10;
      default: return 1;
    endcase
  endfunction

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model(bit tk, bit we, logic [1:0] sel, logic [15:0] d);
    bit adv = 0;
    bit w1 = 0;
    bit w2 = 0;
    if (we && sel < 2) begin
      if (sel == 0) m_c1 = d & 16'hFF0F;
      else          m_c2 = d;
      m_ph = 0;
    end else if (tk) begin
      if (m_ph >= ratio(ctrl_i[1:0]) - 1) begin adv = 1; m_ph = 0; end
      else m_ph++;
    end
    if (we && sel == 2) m_a1 = d;
    if (we && sel == 3) m_a2 = d;
    if (adv) begin
      int n1 = (c1_int(m_c1) + 1) % 600;
      w1 = (n1 == 0);
      m_c1 = int_c1(n1);
      if (w1) begin
        int n2 = (c2_int(m_c2) + 1) % 1440;
        w2 = (n2 == 0);
        m_c2 = int_c2(n2);
      end
    end
    m_tc1 = w1;
    m_tc2 = w1 & w2;
  endtask

  task automatic compare_all();
    bit chain = tod_mode_i & ctrl_i[2] & ctrl_i[3];
    bit e1 = ctrl_i[2] ? (m_c1 == m_a1) : m_tc1;
    bit e2 = ctrl_i[3] ? ((m_c2 == m_a2) && (!chain || m_c1 == m_a1)) : m_tc2;
    check("R2 cnt1", cnt1_o, m_c1);
    check("R3 cnt2", cnt2_o, m_c2);
    check(ctrl_i[2] ? "R5 out1" : "R8 out1", 16'(out1_o), 16'(e1));
    check(chain ? "R7 out2" : (ctrl_i[3] ? "R6 out2" : "R8 out2"), 16'(out2_o), 16'(e2));
  endtask

  task automatic step(bit tk, bit we, logic [1:0] sel, logic [15:0] d);
    line_pulse_i = tk;
    wr_en_i      = we;
    wr_sel_i     = sel;
    wr_data_i    = d;
    @(posedge clk_i);
    model(tk, we, sel, d);
    @(negedge clk_i);
    line_pulse_i = 0;
    wr_en_i      = 0;
    compare_all();
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // reset state
    check("R2 reset cnt1", cnt1_o, 16'h0);
    check("R3 reset cnt2", cnt2_o, 16'h0);
    check("R8 reset out", {14'h0, out2_o, out1_o}, 16'h0);

    // R1: each ratio, counted from a load
    for (int r = 0; r < 4; r++) begin
      ctrl_i = 4'(r);
      step(0, 1, 2'd0, 16'h0000);
      for (int p = 1; p < ratio(2'(r)); p++) step(1, 0, 0, 0);
      check("R1 before Nth pulse", cnt1_o, 16'h0000);
      step(1, 0, 0, 0);
      check("R1 on Nth pulse", cnt1_o, 16'h0001);
    end

    // R4: masked load, then R9 hold
    step(0, 1, 2'd0, 16'h42F7);
    check("R4 cnt1 mask", cnt1_o, 16'h4207);
    step(0, 1, 2'd1, 16'h1130);
    check("R4 cnt2 load", cnt2_o, 16'h1130);
    for (int k = 0; k < 5; k++) step(0, 0, 0, 0);
    check("R9 hold", cnt1_o, 16'h4207);

    // R2/R3/R8: full-day wrap, comparators off
    ctrl_i = 4'b0000;
    step(0, 1, 2'd0, 16'h5909);
    step(0, 1, 2'd1, 16'h2359);
    step(1, 0, 0, 0);
    check("R3 day wrap", cnt2_o, 16'h0000);
    check("R8 tc pulse", {14'h0, out2_o, out1_o}, 16'h0003);
    step(0, 0, 0, 0);
    check("R8 tc one cycle", {14'h0, out2_o, out1_o}, 16'h0000);
    // R2: tenths carry, R3 minute carry
    step(0, 1, 2'd0, 16'h1909);
    step(1, 0, 0, 0);
    check("R2 tenths carry", cnt1_o, 16'h2000);
    step(0, 1, 2'd1, 16'h0959);
    step(0, 1, 2'd0, 16'h5909);
    step(1, 0, 0, 0);
    check("R3 minute carry", cnt2_o, 16'h1000);

    // R7: chained 32-bit alarm
    tod_mode_i = 1;
    ctrl_i = 4'b1100;
    step(0, 1, 2'd2, 16'h1203);
    step(0, 1, 2'd3, 16'h0815);
    step(0, 1, 2'd1, 16'h0815);
    step(0, 1, 2'd0, 16'h1202);
    check("R7 no match yet", {14'h0, out2_o, out1_o}, 16'h0000);
    step(1, 0, 0, 0);
    check("R7 full match", {14'h0, out2_o, out1_o}, 16'h0003);
    step(0, 0, 0, 0);
    check("R5 match holds", 16'(out1_o), 16'h1);
    step(0, 1, 2'd1, 16'h0816);
    check("R7 half match", {14'h0, out2_o, out1_o}, 16'h0001);
    step(0, 1, 2'd1, 16'h0815);
    step(0, 1, 2'd0, 16'h0000);
    check("R7 counter 1 off", {14'h0, out2_o, out1_o}, 16'h0000);
    tod_mode_i = 0;
    step(0, 0, 0, 0);
    check("R6 unchained", 16'(out2_o), 16'h1);

    // random mix
    for (int i = 0; i < 6000; i++) begin
      if (i % 400 == 0) begin
        ctrl_i     = 4'($urandom);
        tod_mode_i = 1'($urandom);
      end
      if ($urandom % 100 < 3) begin
        logic [1:0]  sel = 2'($urandom);
        logic [15:0] d;
        case (sel)
          2'd0:    d = ($urandom % 3 == 0) ? int_c1(595 + $urandom % 5) : int_c1($urandom % 600);
          2'd1:    d = ($urandom % 3 == 0) ? 16'h2359 : int_c2($urandom % 1440);
          2'd2:    d = int_c1((c1_int(m_c1) + $urandom % 4) % 600);
          default: d = int_c2((c2_int(m_c2) + $urandom % 2) % 1440);
        endcase
        step(1'($urandom), 1, sel, d);
      end else begin
        step($urandom % 10 < 7, 0, 0, 0);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule